// File: doc/BRIEF.md
# Pipeline Stage Stall Watchdog with Spare-Core Substitution

This block guards a pipeline of processor cores, where each core sits between an input buffer and an output buffer. A core that has been silenced, for example by a denial-of-service hardware Trojan, stops taking data from its input buffer and stops giving data to its output buffer. The block sees this from the buffer flags and strobes. When a stage has sat in a full-input or empty-output condition for a programmable number of cycles with no read or write activity, the stage raises an alarm. Every stall counter restarts at the boundary of a programmable monitoring window.

The detection logic is built three times, and a bitwise majority vote gives the verdict for each stage. A test input can force any copy's verdict high for every stage. A registered status bit shows when the copies disagree. When a stage raises an alarm, a substitution controller does the following in order:

- It picks the lowest-numbered idle spare core.
- It turns on that spare's clock enable.
- It holds the spare in reset for a fixed number of cycles.
- It maps the spare to the stage.
- It moves the replaced core to the untrusted set and turns off its clock.

A refresh scheduler resets the core of each active stage in turn, on a fixed period, so that time-triggered payloads cannot build up. While a stage's core is in reset, the watchdog ignores that stage.

The data path has no valid/ready interface, because the block only observes buffer flags and strobes. All of its pins are plain control and status signals, and back-pressure does not apply.

Top module: `stage_dos_watchdog`

## Requirements
- R1: A stage's stall count goes up by one on each cycle in which `in_full` or `out_empty` of that stage is high and neither of its strobes is high. The stage's `stage_alarm` is high while the vote over the three copies says the count is at least `cfg_threshold`, with `cfg_threshold` nonzero. `cfg_threshold` = 0 disables alarms.
- R2: A read or write strobe clears the stage's count on that cycle. So does the first cycle of each monitoring window. A window lasts `cfg_interval` cycles, and a value of 0 or 1 makes every cycle a window start.
- R3: The verdict is the bitwise majority of three identical checker copies. `chk_force` bit k forces copy k to report every stage stalled. When one bit is set, no alarm follows from it. When two bits are set, an alarm follows on every stage that is not masked.
- R4: `vote_mismatch` is high in the cycle after a cycle in which the three copies disagreed on any stage, and low otherwise.
- R5: After reset, `core_clk_en` is high for cores 0 to N_STAGE-1 and low for the spare cores N_STAGE to N_STAGE+N_SPARE-1. A spare's enable rises at the edge where that spare is chosen.
- R6: After reset, stage s maps to core s. Field s of `stage_map` is bits [s*CW +: CW], where CW is the core-index width. When the controller is idle and alarms are present, it serves the lowest alarming stage with the lowest idle spare. It updates that stage's map field at the edge that ends the spare's reset. It serves one substitution at a time.
- R7: At the same edge as the map update, the replaced core's `core_untrusted` bit goes high for good and its `core_clk_en` goes low.
- R8: A chosen spare has `core_rst` high for exactly HOLD_CYC cycles, starting in the cycle after it was chosen. Its stage is masked from alarms and its count is held at zero during that time.
- R9: Every REFRESH_PERIOD cycles, the core mapped to the next stage in round-robin order gets `core_rst` for HOLD_CYC cycles. That stage's count is held at zero and its alarm is suppressed while this reset lasts.
- R10: If an alarm is present while the controller is idle and no spare is left, `spares_exhausted` rises and stays high until reset, and the stage map does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | INTV_W | Monitoring window length in cycles |
| cfg_threshold | input | CNT_W | Stall count that raises an alarm (0 disables) |
| in_full | input | N_STAGE | Input buffer of each stage is full |
| out_empty | input | N_STAGE | Output buffer of each stage is empty |
| rd_strobe | input | N_STAGE | Core read from its input buffer this cycle |
| wr_strobe | input | N_STAGE | Core wrote to its output buffer this cycle |
| chk_force | input | 3 | Per-copy force of an all-stalled verdict |
| stage_alarm | output | N_STAGE | Voted, unmasked stall alarm per stage |
| vote_mismatch | output | 1 | Copies disagreed in the previous cycle |
| core_clk_en | output | N_STAGE+N_SPARE | Clock enable per core |
| core_rst | output | N_STAGE+N_SPARE | Reset request per core |
| stage_map | output | N_STAGE*CW | Core index serving each stage |
| core_untrusted | output | N_STAGE+N_SPARE | Core has been quarantined |
| spares_exhausted | output | 1 | Sticky: an alarm found no idle spare |

## Verification
The bench goes after the boundaries of the stall count, each aimed at a specific fault:
- Stalls cut short by strobes, and windows shorter than the threshold, would both falsely alarm if the count were not cleared.
- A short stall would fire early if the compare were off by one.

The voting case checks two things. A single forced copy must stay silent, and a design that ORed the copies instead of voting would swap a healthy core. Two forced copies must cause exactly one substitution. On the substitution path, a wrong spare choice, a reset length off by one, or an enable left on a quarantined core shows up as a difference from the reference model in the cycle it happens. So does a refresh that skips a stage. A last substitution that found no spare and still changed the map, or a failure flag that cleared itself, is caught at the exhaustion step.

// File: rtl/sdw_pkg.sv
`timescale 1ns/1ps
package sdw_pkg;
  // state of the spare substitution controller
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_HOLD = 1'b1
  } swap_state_e;

  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sdw_stall_checker.sv
`timescale 1ns/1ps
// One copy of the per-stage stall detector.
module sdw_stall_checker #(
  parameter int N_STAGE = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               intv_start,
  input  logic               force_all,
  input  logic [CNT_W-1:0]   threshold,
  input  logic [N_STAGE-1:0] in_full,
  input  logic [N_STAGE-1:0] out_empty,
  input  logic [N_STAGE-1:0] rd_strobe,
  input  logic [N_STAGE-1:0] wr_strobe,
  input  logic [N_STAGE-1:0] hold_clear,
  output logic [N_STAGE-1:0] verdict
);
  logic thr_on;
  assign thr_on = (threshold != '0);

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    logic [CNT_W-1:0] cnt_q;
    logic             stalled;
    logic             restart;

    assign stalled = in_full[s] | out_empty[s];
    assign restart = intv_start | hold_clear[s] | rd_strobe[s] | wr_strobe[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (restart) begin
        cnt_q <= '0;
      end else if (stalled && (cnt_q != '1)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign verdict[s] = force_all | (thr_on && (cnt_q >= threshold));
  end
endmodule

// File: rtl/sdw_vote3.sv
`timescale 1ns/1ps
// Bitwise two-of-three vote with a disagreement indication.
module sdw_vote3 #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] maj,
  output logic         disagree
);
  assign maj      = (a & b) | (a & c) | (b & c);
  assign disagree = |((a ^ b) | (a ^ c));
endmodule

// File: rtl/sdw_refresh_sched.sv
`timescale 1ns/1ps
// Round-robin periodic reset of the core serving each stage.
module sdw_refresh_sched #(
  parameter int N_STAGE = 4,
  parameter int PERIOD  = 64,
  parameter int HOLD    = 4,
  localparam int SW     = sdw_pkg::idx_w(N_STAGE),
  localparam int TW     = sdw_pkg::idx_w(PERIOD),
  localparam int LW     = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          active,
  output logic [SW-1:0] stage
);
  logic [TW-1:0] tmr_q;
  logic [LW-1:0] left_q;
  logic [SW-1:0] ptr_q;
  logic          wrap;

  assign wrap = (tmr_q == TW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      left_q <= '0;
      ptr_q  <= '0;
      stage  <= '0;
      active <= 1'b0;
    end else begin
      tmr_q <= wrap ? '0 : tmr_q + 1'b1;
      if (active) begin
        if (left_q == LW'(1)) begin
          active <= 1'b0;
          ptr_q  <= (ptr_q == SW'(N_STAGE - 1)) ? '0 : ptr_q + 1'b1;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end else if (wrap) begin
        active <= 1'b1;
        left_q <= LW'(HOLD);
        stage  <= ptr_q;
      end
    end
  end
endmodule

// File: rtl/sdw_swap_ctrl.sv
`timescale 1ns/1ps
// Picks a spare for an alarming stage, resets it, remaps and quarantines.
module sdw_swap_ctrl #(
  parameter int N_STAGE = 4,
  parameter int N_SPARE = 3,
  parameter int HOLD    = 4,
  localparam int N_CORE = N_STAGE + N_SPARE,
  localparam int CW     = sdw_pkg::idx_w(N_CORE),
  localparam int SW     = sdw_pkg::idx_w(N_STAGE),
  localparam int LW     = $clog2(HOLD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_STAGE-1:0]      alarm,
  output logic [N_STAGE*CW-1:0]   map_flat,
  output logic [N_CORE-1:0]       core_on,
  output logic [N_CORE-1:0]       untrusted,
  output logic                    exhausted,
  output logic                    hold,
  output logic [SW-1:0]           hold_stage,
  output logic [CW-1:0]           hold_spare
);
  import sdw_pkg::*;

  swap_state_e   st_q;
  logic [LW-1:0] left_q;
  logic [CW-1:0] map_q [N_STAGE];
  logic [N_CORE-1:0] free_q;

  logic          stage_found, spare_found;
  logic [SW-1:0] stage_idx;
  logic [CW-1:0] spare_idx;

  always_comb begin
    stage_found = 1'b0;
    stage_idx   = '0;
    for (int s = 0; s < N_STAGE; s++) begin
      if (alarm[s] && !stage_found) begin
        stage_found = 1'b1;
        stage_idx   = SW'(s);
      end
    end
    spare_found = 1'b0;
    spare_idx   = '0;
    for (int c = 0; c < N_CORE; c++) begin
      if (free_q[c] && !spare_found) begin
        spare_found = 1'b1;
        spare_idx   = CW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SW_IDLE;
      left_q     <= '0;
      hold_stage <= '0;
      hold_spare <= '0;
      exhausted  <= 1'b0;
      untrusted  <= '0;
      for (int s = 0; s < N_STAGE; s++) map_q[s] <= CW'(s);
      for (int c = 0; c < N_CORE; c++) begin
        core_on[c] <= (c < N_STAGE);
        free_q[c]  <= (c >= N_STAGE);
      end
    end else begin
      case (st_q)
        SW_IDLE: begin
          if (stage_found) begin
            if (spare_found) begin
              free_q[spare_idx]  <= 1'b0;
              core_on[spare_idx] <= 1'b1;
              hold_stage         <= stage_idx;
              hold_spare         <= spare_idx;
              left_q             <= LW'(HOLD);
              st_q               <= SW_HOLD;
            end else begin
              exhausted <= 1'b1;
            end
          end
        end
        SW_HOLD: begin
          if (left_q == LW'(1)) begin
            map_q[hold_stage]            <= hold_spare;
            untrusted[map_q[hold_stage]] <= 1'b1;
            core_on[map_q[hold_stage]]   <= 1'b0;
            st_q                         <= SW_IDLE;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  assign hold = (st_q == SW_HOLD);

  for (genvar s = 0; s < N_STAGE; s++) begin : g_flat
    assign map_flat[s*CW +: CW] = map_q[s];
  end
endmodule

// File: rtl/stage_dos_watchdog.sv
`timescale 1ns/1ps
// Pipeline stage stall watchdog with triplicated detection and spare swap.
module stage_dos_watchdog #(
  parameter int N_STAGE        = 4,
  parameter int N_SPARE        = 3,
  parameter int CNT_W          = 8,
  parameter int INTV_W         = 12,
  parameter int HOLD_CYC       = 4,
  parameter int REFRESH_PERIOD = 64,
  localparam int N_CORE        = N_STAGE + N_SPARE,
  localparam int CW            = sdw_pkg::idx_w(N_CORE),
  localparam int SW            = sdw_pkg::idx_w(N_STAGE),
  localparam int N_COPY        = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INTV_W-1:0]     cfg_interval,
  input  logic [CNT_W-1:0]      cfg_threshold,
  input  logic [N_STAGE-1:0]    in_full,
  input  logic [N_STAGE-1:0]    out_empty,
  input  logic [N_STAGE-1:0]    rd_strobe,
  input  logic [N_STAGE-1:0]    wr_strobe,
  input  logic [N_COPY-1:0]     chk_force,
  output logic [N_STAGE-1:0]    stage_alarm,
  output logic                  vote_mismatch,
  output logic [N_CORE-1:0]     core_clk_en,
  output logic [N_CORE-1:0]     core_rst,
  output logic [N_STAGE*CW-1:0] stage_map,
  output logic [N_CORE-1:0]     core_untrusted,
  output logic                  spares_exhausted
);
  // monitoring window
  logic [INTV_W-1:0] intv_q;
  logic              intv_start;
  assign intv_start = (intv_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intv_q <= '0;
    end else if ((cfg_interval <= INTV_W'(1)) || (intv_q >= cfg_interval - INTV_W'(1))) begin
      intv_q <= '0;
    end else begin
      intv_q <= intv_q + 1'b1;
    end
  end

  // refresh scheduler
  logic          ref_active;
  logic [SW-1:0] ref_stage;

  sdw_refresh_sched #(
    .N_STAGE(N_STAGE), .PERIOD(REFRESH_PERIOD), .HOLD(HOLD_CYC)
  ) u_refresh (
    .clk(clk), .rst_n(rst_n), .active(ref_active), .stage(ref_stage)
  );

  // substitution controller status
  logic          sw_hold;
  logic [SW-1:0] sw_stage;
  logic [CW-1:0] sw_spare;

  // stages whose core is in reset are ignored
  logic [N_STAGE-1:0] stage_mask;
  for (genvar s = 0; s < N_STAGE; s++) begin : g_mask
    assign stage_mask[s] = (ref_active && (ref_stage == SW'(s))) ||
                           (sw_hold && (sw_stage == SW'(s)));
  end

  // triplicated detection
  logic [N_STAGE-1:0] verdict [N_COPY];
  for (genvar k = 0; k < N_COPY; k++) begin : g_copy
    sdw_stall_checker #(.N_STAGE(N_STAGE), .CNT_W(CNT_W)) u_chk (
      .clk(clk), .rst_n(rst_n), .intv_start(intv_start),
      .force_all(chk_force[k]), .threshold(cfg_threshold),
      .in_full(in_full), .out_empty(out_empty),
      .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
      .hold_clear(stage_mask), .verdict(verdict[k])
    );
  end

  logic [N_STAGE-1:0] voted;
  logic               copies_differ;

  sdw_vote3 #(.W(N_STAGE)) u_vote (
    .a(verdict[0]), .b(verdict[1]), .c(verdict[2]),
    .maj(voted), .disagree(copies_differ)
  );

  assign stage_alarm = voted & ~stage_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vote_mismatch <= 1'b0;
    else        vote_mismatch <= copies_differ;
  end

  sdw_swap_ctrl #(
    .N_STAGE(N_STAGE), .N_SPARE(N_SPARE), .HOLD(HOLD_CYC)
  ) u_swap (
    .clk(clk), .rst_n(rst_n), .alarm(stage_alarm),
    .map_flat(stage_map), .core_on(core_clk_en), .untrusted(core_untrusted),
    .exhausted(spares_exhausted), .hold(sw_hold),
    .hold_stage(sw_stage), .hold_spare(sw_spare)
  );

  // core reset requests
  logic [CW-1:0] map_arr [N_STAGE];
  for (genvar s = 0; s < N_STAGE; s++) begin : g_unpack
    assign map_arr[s] = stage_map[s*CW +: CW];
  end

  logic [CW-1:0] ref_core;
  assign ref_core = map_arr[ref_stage];

  for (genvar c = 0; c < N_CORE; c++) begin : g_rst
    assign core_rst[c] = (ref_active && (ref_core == CW'(c))) ||
                         (sw_hold && (sw_spare == CW'(c)));
  end
endmodule

// File: rtl/stage_dos_watchdog_chk.sv
`timescale 1ns/1ps
// Property checker attached to the watchdog top.
module stage_dos_watchdog_chk #(
  parameter int N_STAGE = 4,
  parameter int N_CORE  = 7,
  parameter int CW      = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            chk_force,
  input logic                  vote_mismatch,
  input logic [N_CORE-1:0]     core_clk_en,
  input logic [N_CORE-1:0]     core_rst,
  input logic [N_STAGE*CW-1:0] stage_map,
  input logic [N_CORE-1:0]     core_untrusted,
  input logic                  spares_exhausted
);
  logic map_dup, mapped_off;
  always_comb begin
    map_dup    = 1'b0;
    mapped_off = 1'b0;
    for (int i = 0; i < N_STAGE; i++) begin
      if (!core_clk_en[stage_map[i*CW +: CW]]) mapped_off = 1'b1;
      for (int j = i + 1; j < N_STAGE; j++) begin
        if (stage_map[i*CW +: CW] == stage_map[j*CW +: CW]) map_dup = 1'b1;
      end
    end
  end

  p_no_mismatch_unforced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_force == 3'b000) |=> !vote_mismatch);

  p_mapped_core_clocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped_off);

  p_map_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !map_dup);

  p_untrusted_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_untrusted & core_clk_en) == '0);

  p_reset_core_clocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst & ~core_clk_en) == '0);

  p_exhausted_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spares_exhausted |=> spares_exhausted);
endmodule

bind stage_dos_watchdog stage_dos_watchdog_chk #(
  .N_STAGE(N_STAGE), .N_CORE(N_CORE), .CW(CW)
) u_props (
  .clk(clk), .rst_n(rst_n), .chk_force(chk_force),
  .vote_mismatch(vote_mismatch), .core_clk_en(core_clk_en),
  .core_rst(core_rst), .stage_map(stage_map),
  .core_untrusted(core_untrusted), .spares_exhausted(spares_exhausted)
);

// File: tb/stage_dos_watchdog_tb_top.sv
`timescale 1ns/1ps
module stage_dos_watchdog_tb_top;
  localparam int S = 4, SP = 3, C = 7, CW = 3, HOLD = 4, PER = 64, CMAX = 255;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [11:0]   cfg_interval;
  logic [7:0]    cfg_threshold;
  logic [S-1:0]  in_full, out_empty, rd_strobe, wr_strobe;
  logic [2:0]    chk_force;
  logic [S-1:0]  stage_alarm;
  logic          vote_mismatch;
  logic [C-1:0]  core_clk_en, core_rst, core_untrusted;
  logic [S*CW-1:0] stage_map;
  logic          spares_exhausted;

  stage_dos_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_threshold(cfg_threshold),
    .in_full(in_full), .out_empty(out_empty), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .chk_force(chk_force), .stage_alarm(stage_alarm), .vote_mismatch(vote_mismatch),
    .core_clk_en(core_clk_en), .core_rst(core_rst), .stage_map(stage_map),
    .core_untrusted(core_untrusted), .spares_exhausted(spares_exhausted)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_intv, m_cnt[S], m_map[S];
  bit m_untr[C], m_on[C], m_free[C];
  bit m_fail, m_hold, m_mism, m_ract, m_live;
  int m_left, m_sst, m_ssp, m_rtmr, m_rleft, m_rstage, m_rptr;

  function automatic bit m_mask(int s);
    return (m_ract && m_rstage == s) || (m_hold && m_sst == s);
  endfunction
  function automatic int m_votes(int s);
    int v = 0;
    bit det = (cfg_threshold != 0) && (m_cnt[s] >= int'(cfg_threshold));
    for (int k = 0; k < 3; k++) if (det || chk_force[k]) v++;
    return v;
  endfunction
  function automatic bit m_alarm(int s);
    return (m_votes(s) >= 2) && !m_mask(s);
  endfunction
  function automatic logic [S-1:0] exp_alarm();
    logic [S-1:0] r;
    for (int s = 0; s < S; s++) r[s] = m_alarm(s);
    return r;
  endfunction
  function automatic logic [S*CW-1:0] exp_map();
    logic [S*CW-1:0] r;
    for (int s = 0; s < S; s++) r[s*CW +: CW] = CW'(m_map[s]);
    return r;
  endfunction
  function automatic logic [C-1:0] exp_rst();
    logic [C-1:0] r;
    for (int c = 0; c < C; c++)
      r[c] = (m_ract && m_map[m_rstage] == c) || (m_hold && m_ssp == c);
    return r;
  endfunction
  function automatic logic [C-1:0] pack_bits(input bit v[C]);
    logic [C-1:0] r;
    for (int c = 0; c < C; c++) r[c] = v[c];
    return r;
  endfunction

  task automatic m_init();
    m_intv = 0; m_fail = 0; m_hold = 0; m_mism = 0; m_ract = 0;
    m_left = 0; m_sst = 0; m_ssp = 0; m_rtmr = 0; m_rleft = 0; m_rstage = 0; m_rptr = 0;
    for (int s = 0; s < S; s++) begin m_cnt[s] = 0; m_map[s] = s; end
    for (int c = 0; c < C; c++) begin m_untr[c] = 0; m_on[c] = (c < S); m_free[c] = (c >= S); end
    m_live = 1;
  endtask

  task automatic m_step();
    bit al[S], msk[S], differ, any;
    int ls, lf, nv;
    differ = 0; ls = -1; lf = -1;
    for (int s = 0; s < S; s++) begin
      msk[s] = m_mask(s);
      al[s]  = m_alarm(s);
      nv = m_votes(s);
      if (nv != 0 && nv != 3) differ = 1;
      if (al[s] && ls < 0) ls = s;
    end
    any = (ls >= 0);
    for (int c = 0; c < C; c++) if (m_free[c] && lf < 0) lf = c;
    // counters
    for (int s = 0; s < S; s++) begin
      if (m_intv == 0 || msk[s] || rd_strobe[s] || wr_strobe[s]) m_cnt[s] = 0;
      else if ((in_full[s] || out_empty[s]) && m_cnt[s] < CMAX) m_cnt[s]++;
    end
    m_mism = differ;
    if (cfg_interval <= 1 || m_intv >= int'(cfg_interval) - 1) m_intv = 0; else m_intv++;
    // substitution
    if (!m_hold) begin
      if (any) begin
        if (lf >= 0) begin
          m_free[lf] = 0; m_on[lf] = 1; m_sst = ls; m_ssp = lf; m_left = HOLD; m_hold = 1;
        end else m_fail = 1;
      end
    end else if (m_left == 1) begin
      m_untr[m_map[m_sst]] = 1; m_on[m_map[m_sst]] = 0; m_map[m_sst] = m_ssp; m_hold = 0;
    end else m_left--;
    // refresh
    if (m_ract) begin
      if (m_rleft == 1) begin m_ract = 0; m_rptr = (m_rptr + 1) % S; end
      else m_rleft--;
    end else if (m_rtmr == PER - 1) begin
      m_ract = 1; m_rleft = HOLD; m_rstage = m_rptr;
    end
    m_rtmr = (m_rtmr == PER - 1) ? 0 : m_rtmr + 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_init();
    else if (m_live) m_step();
  end

  // per-cycle comparison, away from the active edge
  int alarm_seen = 0;
  int rst_cycles[C];
  always @(negedge clk) begin
    if (rst_n && m_live && !done) begin
      chk(stage_alarm == exp_alarm(), "R1 R9", "stage_alarm", stage_alarm, exp_alarm());
      chk(vote_mismatch == m_mism, "R4", "vote_mismatch", vote_mismatch, m_mism);
      chk(core_clk_en == pack_bits(m_on), "R5", "core_clk_en", core_clk_en, pack_bits(m_on));
      chk(stage_map == exp_map(), "R6", "stage_map", stage_map, exp_map());
      chk(core_untrusted == pack_bits(m_untr), "R7", "core_untrusted", core_untrusted, pack_bits(m_untr));
      chk(core_rst == exp_rst(), "R8 R9", "core_rst", core_rst, exp_rst());
      chk(spares_exhausted == m_fail, "R10", "spares_exhausted", spares_exhausted, m_fail);
      if (|stage_alarm) alarm_seen++;
      for (int c = 0; c < C; c++) if (core_rst[c]) rst_cycles[c]++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  function automatic int map_of(int s);
    return int'(stage_map[s*CW +: CW]);
  endfunction
  task automatic wait_quiet();
    int i = 0;
    while (!(!m_ract && !m_hold && m_rtmr < 30) && i < 500) begin step(1); i++; end
  endtask
  task automatic wait_map_change(input int s, input int old);
    int i = 0;
    while (m_map[s] == old && i < 3000) begin step(1); i++; end
  endtask

  initial begin
    rst_n = 0; cfg_interval = 12'd50; cfg_threshold = 8'd10; chk_force = 3'b000;
    in_full = '0; out_empty = '0; rd_strobe = '0; wr_strobe = '0;
    for (int c = 0; c < C; c++) rst_cycles[c] = 0;
    m_live = 0;
    step(3);
    // reset state
    chk(stage_map == 12'b011_010_001_000, "R6", "identity map after reset", stage_map, 12'b011_010_001_000);
    chk(core_clk_en == 7'b0001111, "R5", "clock enables after reset", core_clk_en, 7'b0001111);
    chk(core_untrusted == '0 && !spares_exhausted, "R7 R10", "lists after reset", core_untrusted, 0);
    rst_n = 1;
    step(2);

    // R2: strobes keep clearing a stall
    alarm_seen = 0;
    in_full[0] = 1'b1;
    for (int i = 0; i < 40; i++) begin
      rd_strobe[0] = 1'b1; step(1); rd_strobe[0] = 1'b0; step(4);
    end
    wr_strobe[0] = 1'b1; in_full[0] = 1'b0; step(1); wr_strobe[0] = 1'b0;
    chk(alarm_seen == 0, "R2", "alarms with strobes every 5 cycles", alarm_seen, 0);

    // R2: window shorter than threshold
    cfg_interval = 12'd8; alarm_seen = 0;
    in_full[0] = 1'b1; step(100); in_full[0] = 1'b0;
    rd_strobe[0] = 1'b1; step(1); rd_strobe[0] = 1'b0; cfg_interval = 12'd50;
    chk(alarm_seen == 0, "R2", "alarms with window 8 below threshold 10", alarm_seen, 0);

    // R1: short stall below threshold
    alarm_seen = 0;
    out_empty[2] = 1'b1; step(5); out_empty[2] = 1'b0;
    wr_strobe[2] = 1'b1; step(1); wr_strobe[2] = 1'b0; step(5);
    chk(alarm_seen == 0, "R1", "alarms after 5-cycle stall", alarm_seen, 0);

    // R9: every active core refreshed once per S*PER cycles
    for (int c = 0; c < C; c++) rst_cycles[c] = 0;
    step(S * PER);
    for (int c = 0; c < S; c++)
      chk(rst_cycles[c] == HOLD, "R9", "refresh reset cycles", rst_cycles[c], HOLD);
    chk(rst_cycles[4] + rst_cycles[5] + rst_cycles[6] == 0, "R9", "spare resets", rst_cycles[4], 0);

    // R3/R4: one forced copy is outvoted, disagreement reported
    alarm_seen = 0; chk_force = 3'b010; step(100);
    chk(alarm_seen == 0, "R3", "alarms with one forced copy", alarm_seen, 0);
    chk(vote_mismatch == 1'b1, "R4", "mismatch with one forced copy", vote_mismatch, 1);
    chk_force = 3'b000; step(2);
    chk(vote_mismatch == 1'b0, "R4", "mismatch after release", vote_mismatch, 0);

    // R6/R7/R5: stall stage 1 until substituted by spare 4
    wait_quiet();
    in_full[1] = 1'b1;
    wait_map_change(1, 1);
    in_full[1] = 1'b0; step(5);
    chk(map_of(1) == 4, "R6", "stage 1 core", map_of(1), 4);
    chk(core_untrusted == 7'b0000010, "R7", "untrusted after first swap", core_untrusted, 7'b0000010);
    chk(core_clk_en == 7'b0011101, "R5", "enables after first swap", core_clk_en, 7'b0011101);

    // R3: two forced copies win the vote, lowest stage 0 gets spare 5
    wait_quiet();
    chk_force = 3'b011;
    begin int i = 0; while (!m_hold && i < 200) begin step(1); i++; end end
    chk_force = 3'b000;
    wait_map_change(0, 0); step(3);
    chk(map_of(0) == 5, "R3", "stage 0 core after majority force", map_of(0), 5);
    chk(core_untrusted == 7'b0000011, "R7", "untrusted after second swap", core_untrusted, 7'b0000011);

    // R10: use the last spare, then run out
    out_empty[2] = 1'b1; wait_map_change(2, 2); out_empty[2] = 1'b0; step(3);
    chk(map_of(2) == 6, "R6", "stage 2 core", map_of(2), 6);
    in_full[3] = 1'b1;
    begin int i = 0; while (!m_fail && i < 3000) begin step(1); i++; end end
    in_full[3] = 1'b0; rd_strobe[3] = 1'b1; step(1); rd_strobe[3] = 1'b0; step(20);
    chk(spares_exhausted == 1'b1, "R10", "exhausted flag", spares_exhausted, 1);
    chk(map_of(3) == 3, "R10", "stage 3 map unchanged", map_of(3), 3);
    chk(core_clk_en[3] == 1'b1, "R10", "stage 3 core still clocked", core_clk_en[3], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule